// File: doc/BRIEF.md
# Threshold-Driven Data FIFO with DMA Requests

This block is a 32-deep, 16-bit data buffer that sits between a host-side data register and a card-side word stream. The transfer direction input picks which side fills the buffer and which side drains it. In receive direction the card side pushes and the host side pops. In transmit direction the host side pushes and the card side pops. The word at the head of the buffer is always shown on one read-data output, and both sides read it from there.

Two programmable watermarks watch the fill count. These are an almost-full level for receive and an almost-empty level for transmit. When a watermark is crossed, the block either raises a DMA request line for that direction or sets a level flag for software polling. It never does both. A configuration strobe loads both levels and the two per-direction DMA enable bits together. The flags and request lines are registered. They change on the same clock edge that updates the fill count or the configuration.

Top module: `lvl_fifo`

## Requirements
- R1: After reset the fill count is 0, both flags and both request lines are low, the almost-full level is 31, the almost-empty level is 0 and both DMA enables are off. With these defaults, receive-direction pushes raise flag_rx only when the count reaches 32.
- R2: With dir_rx=1, card_wr pushes card_wdata and host_rd pops. With dir_rx=0, host_wr pushes host_wdata and card_rd pops. The strobes of the other side are ignored. Words leave in the order they entered, and this holds across pointer wrap.
- R3: A push while the count is 32 is dropped. The count stays at 32 and the stored words are unchanged. The count never exceeds 32.
- R4: A pop while the count is 0 changes neither the count nor the head pointer. head_data keeps showing the word stored at the head slot.
- R5: A push and a pop in the same cycle on a buffer holding 1 to 31 words both take effect, so the count is unchanged.
- R6: In receive direction with count > almost-full level, rx_dma_req is 1 and flag_rx is 0 if receive DMA is enabled. If receive DMA is disabled, flag_rx is 1 and rx_dma_req is 0.
- R7: In transmit direction with count < almost-empty level, tx_dma_req is 1 and flag_tx is 0 if transmit DMA is enabled. If transmit DMA is disabled, flag_tx is 1 and tx_dma_req is 0.
- R8: If the condition of R6 does not hold, rx_dma_req and flag_rx are 0. If the condition of R7 does not hold, tx_dma_req and flag_tx are 0. R9 takes priority over this rule.
- R9: When xfer_active is 0 and the count is 0, both flags are cleared and both request lines keep their previous values.
- R10: A configuration write that enables a direction's DMA clears that direction's flag by the following cycle.
- R11: Flags, request lines and fill_count all reflect the state after the same rising edge that applies a push, pop or configuration write. Each output is evaluated from the values its inputs held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host push strobe (transmit direction) |
| host_wdata | input | 16 | Host push data |
| host_rd | input | 1 | Host pop strobe (receive direction) |
| card_wr | input | 1 | Card push strobe (receive direction) |
| card_wdata | input | 16 | Card push data |
| card_rd | input | 1 | Card pop strobe (transmit direction) |
| head_data | output | 16 | Word at the head slot |
| cfg_wr | input | 1 | Load levels and DMA enables |
| cfg_af_level | input | 5 | Almost-full level |
| cfg_ae_level | input | 5 | Almost-empty level |
| cfg_rx_dma_en | input | 1 | Receive DMA enable |
| cfg_tx_dma_en | input | 1 | Transmit DMA enable |
| dir_rx | input | 1 | 1 = receive, 0 = transmit |
| xfer_active | input | 1 | Transfer in progress |
| fill_count | output | 6 | Words held, 0 to 32 |
| flag_rx | output | 1 | Receive level flag |
| flag_tx | output | 1 | Transmit level flag |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
A push and a pop can land in the same cycle. This is provoked both on a half-filled buffer and at the two edges: a full buffer, where the push must be dropped while the pop proceeds, and an empty buffer, where the pop must be ignored while the push proceeds. A configuration write can also coincide with a count change, so the watermark decision must use the new count and the new levels together. A bench model updates on every edge and is compared against every output on every cycle. Directed and random strobe mixes drive all of these coincidences.

// File: rtl/lvl_fifo_pkg.sv
package lvl_fifo_pkg;
  localparam int FIFO_DEPTH = 32;
  localparam int FIFO_WIDTH = 16;
  localparam int LVL_W      = $clog2(FIFO_DEPTH);
  localparam int CNT_W      = LVL_W + 1;

  typedef struct packed {
    logic [LVL_W-1:0] af_level;
    logic [LVL_W-1:0] ae_level;
    logic             rx_dma_en;
    logic             tx_dma_en;
  } lvl_cfg_t;
endpackage

// File: rtl/lvl_fifo_store.sv
module lvl_fifo_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    count_nxt
);
  // DEPTH must be a power of two: pointers wrap by truncation.
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    start_q, start_d, wr_idx;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  always_comb begin
    do_push = push && (cnt_q != FULL);
    do_pop  = pop && (cnt_q != '0);
    wr_idx  = start_q + cnt_q[PW-1:0];
    start_d = start_q;
    cnt_d   = cnt_q;
    if (do_pop) start_d = start_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= wdata;
  end

  assign rdata     = mem[start_q];
  assign count     = cnt_q;
  assign count_nxt = cnt_d;
endmodule

// File: rtl/lvl_fifo_thresh.sv
module lvl_fifo_thresh
  import lvl_fifo_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  count_nxt,
  input  logic           cfg_wr,
  input  lvl_cfg_t       cfg_in,
  input  logic           dir_rx,
  input  logic           xfer_active,
  output logic           flag_rx,
  output logic           flag_tx,
  output logic           rx_req,
  output logic           tx_req
);
  lvl_cfg_t cfg_q, cfg_d;
  logic     frx_d, ftx_d, rrq_d, trq_d;
  logic     rx_hit, tx_hit;

  always_comb begin
    cfg_d  = cfg_wr ? cfg_in : cfg_q;
    rx_hit = dir_rx && (count_nxt > {1'b0, cfg_d.af_level});
    tx_hit = !dir_rx && (count_nxt < {1'b0, cfg_d.ae_level});
    frx_d  = 1'b0;
    ftx_d  = 1'b0;
    rrq_d  = rx_req;
    trq_d  = tx_req;
    if (xfer_active || (count_nxt != '0)) begin
      rrq_d = rx_hit && cfg_d.rx_dma_en;
      frx_d = rx_hit && !cfg_d.rx_dma_en;
      trq_d = tx_hit && cfg_d.tx_dma_en;
      ftx_d = tx_hit && !cfg_d.tx_dma_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.af_level  <= LVL_W'(DEPTH - 1);
      cfg_q.ae_level  <= '0;
      cfg_q.rx_dma_en <= 1'b0;
      cfg_q.tx_dma_en <= 1'b0;
      flag_rx         <= 1'b0;
      flag_tx         <= 1'b0;
      rx_req          <= 1'b0;
      tx_req          <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_d;
      flag_rx <= frx_d;
      flag_tx <= ftx_d;
      rx_req  <= rrq_d;
      tx_req  <= trq_d;
    end
  end
endmodule

// File: rtl/lvl_fifo.sv
module lvl_fifo
  import lvl_fifo_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr,
  input  logic [FIFO_WIDTH-1:0] host_wdata,
  input  logic                  host_rd,
  input  logic                  card_wr,
  input  logic [FIFO_WIDTH-1:0] card_wdata,
  input  logic                  card_rd,
  output logic [FIFO_WIDTH-1:0] head_data,
  input  logic                  cfg_wr,
  input  logic [LVL_W-1:0]      cfg_af_level,
  input  logic [LVL_W-1:0]      cfg_ae_level,
  input  logic                  cfg_rx_dma_en,
  input  logic                  cfg_tx_dma_en,
  input  logic                  dir_rx,
  input  logic                  xfer_active,
  output logic [CNT_W-1:0]      fill_count,
  output logic                  flag_rx,
  output logic                  flag_tx,
  output logic                  rx_dma_req,
  output logic                  tx_dma_req
);
  logic                  push_sel, pop_sel;
  logic [FIFO_WIDTH-1:0] wdata_sel;
  logic [CNT_W-1:0]      cnt_nxt;
  lvl_cfg_t              cfg_in;

  always_comb begin
    push_sel  = dir_rx ? card_wr : host_wr;
    pop_sel   = dir_rx ? host_rd : card_rd;
    wdata_sel = dir_rx ? card_wdata : host_wdata;
    cfg_in.af_level  = cfg_af_level;
    cfg_in.ae_level  = cfg_ae_level;
    cfg_in.rx_dma_en = cfg_rx_dma_en;
    cfg_in.tx_dma_en = cfg_tx_dma_en;
  end

  lvl_fifo_store #(.DEPTH(FIFO_DEPTH), .WIDTH(FIFO_WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_sel),
    .pop       (pop_sel),
    .wdata     (wdata_sel),
    .rdata     (head_data),
    .count     (fill_count),
    .count_nxt (cnt_nxt)
  );

  lvl_fifo_thresh #(.DEPTH(FIFO_DEPTH)) u_thresh (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_nxt   (cnt_nxt),
    .cfg_wr      (cfg_wr),
    .cfg_in      (cfg_in),
    .dir_rx      (dir_rx),
    .xfer_active (xfer_active),
    .flag_rx     (flag_rx),
    .flag_tx     (flag_tx),
    .rx_req      (rx_dma_req),
    .tx_req      (tx_dma_req)
  );
endmodule

// File: rtl/lvl_fifo_chk.sv
module lvl_fifo_chk
  import lvl_fifo_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  host_wr,
  input logic                  host_rd,
  input logic                  card_wr,
  input logic                  card_rd,
  input logic                  dir_rx,
  input logic                  xfer_active,
  input logic [FIFO_WIDTH-1:0] head_data,
  input logic [CNT_W-1:0]      fill_count,
  input logic                  flag_rx,
  input logic                  flag_tx,
  input logic                  rx_dma_req,
  input logic                  tx_dma_req
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);
  logic psh, pp;
  assign psh = dir_rx ? card_wr : host_wr;
  assign pp  = dir_rx ? host_rd : card_rd;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= FULL);
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == FULL && psh && !pp) |=> fill_count == FULL);
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0 && pp && !psh) |=> (fill_count == '0 && $stable(head_data)));
  // R5
  both_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count != '0 && fill_count != FULL && psh && pp) |=> $stable(fill_count));
  // R6
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_rx && rx_dma_req));
  // R7
  tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_tx && tx_dma_req));
  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!xfer_active) && fill_count == '0) |-> (!flag_rx && !flag_tx));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!xfer_active) && fill_count == '0 && $past(fill_count) == '0)
      |-> ($stable(rx_dma_req) && $stable(tx_dma_req)));
endmodule

bind lvl_fifo lvl_fifo_chk u_chk (.*);

// File: tb/lvl_fifo_bench.sv
module lvl_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 0, host_rd = 0, card_wr = 0, card_rd = 0;
  logic [15:0] host_wdata = 0, card_wdata = 0;
  logic        cfg_wr = 0, cfg_rx_dma_en = 0, cfg_tx_dma_en = 0;
  logic [4:0]  cfg_af_level = 0, cfg_ae_level = 0;
  logic        dir_rx = 0, xfer_active = 0;
  logic [15:0] head_data;
  logic [5:0]  fill_count;
  logic        flag_rx, flag_tx, rx_dma_req, tx_dma_req;

  int checks = 0, errors = 0, cycles = 0;

  lvl_fifo u_lvl_fifo (.*);

  always #10 clk = ~clk;

  // behavioural reference
  int m_data [32];
  bit m_valid [32];
  int m_start = 0, m_cnt = 0, m_af = 31, m_ae = 0;
  bit m_rxen = 0, m_txen = 0, m_frx = 0, m_ftx = 0, m_rrq = 0, m_trq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0; m_cnt = 0; m_af = 31; m_ae = 0;
      m_rxen = 0; m_txen = 0; m_frx = 0; m_ftx = 0; m_rrq = 0; m_trq = 0;
    end else begin
      bit p, q, rh, th;
      int wd;
      p  = dir_rx ? card_wr : host_wr;
      q  = dir_rx ? host_rd : card_rd;
      wd = dir_rx ? card_wdata : host_wdata;
      if (m_cnt == 32) p = 0;
      if (m_cnt == 0) q = 0;
      if (p) begin
        m_data[(m_start + m_cnt) % 32] = wd;
        m_valid[(m_start + m_cnt) % 32] = 1;
      end
      if (q) m_start = (m_start + 1) % 32;
      m_cnt = m_cnt + int'(p) - int'(q);
      if (cfg_wr) begin
        m_af = cfg_af_level; m_ae = cfg_ae_level;
        m_rxen = cfg_rx_dma_en; m_txen = cfg_tx_dma_en;
      end
      m_frx = 0; m_ftx = 0;
      if (xfer_active || m_cnt != 0) begin
        rh = dir_rx && (m_cnt > m_af);
        th = !dir_rx && (m_cnt < m_ae);
        m_rrq = rh && m_rxen;  m_frx = rh && !m_rxen;
        m_trq = th && m_txen;  m_ftx = th && !m_txen;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk(fill_count == 6'(m_cnt), "R11 fill_count", fill_count, m_cnt);
      chk(flag_rx == m_frx, "R6 flag_rx", flag_rx, m_frx);
      chk(flag_tx == m_ftx, "R7 flag_tx", flag_tx, m_ftx);
      chk(rx_dma_req == m_rrq, "R8 rx_dma_req", rx_dma_req, m_rrq);
      chk(tx_dma_req == m_trq, "R9 tx_dma_req", tx_dma_req, m_trq);
      if (m_valid[m_start])
        chk(head_data == 16'(m_data[m_start]), "R2 head_data", head_data, m_data[m_start]);
    end
  end

  task automatic step();
    @(negedge clk);
    host_wr = 0; host_rd = 0; card_wr = 0; card_rd = 0; cfg_wr = 0;
  endtask

  task automatic cfg(input int af, input int ae, input bit rxe, input bit txe);
    cfg_af_level = 5'(af); cfg_ae_level = 5'(ae);
    cfg_rx_dma_en = rxe; cfg_tx_dma_en = txe; cfg_wr = 1;
    step();
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fill_count == 0 && !flag_rx && !flag_tx && !rx_dma_req && !tx_dma_req,
        "R1 reset outputs", {fill_count, flag_rx, flag_tx, rx_dma_req, tx_dma_req}, 0);
    rst_n = 1;
    step();
    // R1/R6 default almost-full level 31 in receive direction
    dir_rx = 1; xfer_active = 1;
    for (int i = 0; i < 31; i++) begin
      card_wr = 1; card_wdata = 16'(16'h1000 + i); step();
    end
    chk(flag_rx == 0, "R1 flag_rx at 31", flag_rx, 0);
    card_wr = 1; card_wdata = 16'h101f; step();
    chk(flag_rx == 1 && rx_dma_req == 0, "R6 flag_rx at 32", flag_rx, 1);
    // R3 push on full dropped
    card_wr = 1; card_wdata = 16'hdead; step();
    chk(fill_count == 32, "R3 full count", fill_count, 32);
    // R2 host-side push ignored in receive direction
    host_wr = 1; host_wdata = 16'hbeef; step();
    chk(fill_count == 32, "R2 ignored host_wr", fill_count, 32);
    // R3 push at full together with pop: pop only
    card_wr = 1; card_wdata = 16'hdead; host_rd = 1; step();
    chk(fill_count == 31 && flag_rx == 0, "R8 after pop", fill_count, 31);
    chk(head_data == 16'h1001, "R3 order after full", head_data, 16'h1001);
    // R2 drain and check order
    for (int i = 1; i < 32; i++) begin
      chk(head_data == 16'(16'h1000 + i), "R2 order", head_data, 16'h1000 + i);
      host_rd = 1; step();
    end
    chk(fill_count == 0, "R2 drained", fill_count, 0);
    // R4 pop on empty
    host_rd = 1; step();
    chk(fill_count == 0 && head_data == 16'h1000, "R4 empty pop", head_data, 16'h1000);
    // R6 with DMA
    cfg(3, 0, 1, 0);
    for (int i = 0; i < 4; i++) begin
      card_wr = 1; card_wdata = 16'(16'h2000 + i); step();
    end
    chk(rx_dma_req == 1 && flag_rx == 0, "R6 rx dma", rx_dma_req, 1);
    // R5 simultaneous push and pop
    card_wr = 1; card_wdata = 16'h2004; host_rd = 1; step();
    chk(fill_count == 4 && head_data == 16'h2001, "R5 both", fill_count, 4);
    // R8 drop below level
    host_rd = 1; step();
    chk(rx_dma_req == 0, "R8 rx req low", rx_dma_req, 0);
    for (int i = 0; i < 3; i++) begin host_rd = 1; step(); end
    // R7 transmit without DMA, R10 enabling DMA
    dir_rx = 0; cfg(31, 5, 0, 0);
    chk(flag_tx == 1 && tx_dma_req == 0, "R7 flag_tx", flag_tx, 1);
    cfg(31, 5, 0, 1);
    chk(flag_tx == 0 && tx_dma_req == 1, "R10 tx dma clears flag", flag_tx, 0);
    // R9 idle and empty: flags clear, request held
    xfer_active = 0; step();
    chk(tx_dma_req == 1 && flag_tx == 0, "R9 hold req", tx_dma_req, 1);
    cfg(31, 5, 0, 0);
    chk(flag_tx == 0 && tx_dma_req == 1, "R9 idle flag clear", flag_tx, 0);
    xfer_active = 1; cfg(31, 5, 0, 1);
    for (int i = 0; i < 5; i++) begin
      host_wr = 1; host_wdata = 16'(16'h3000 + i); step();
    end
    chk(tx_dma_req == 0 && flag_tx == 0, "R8 tx req low", tx_dma_req, 0);
    // R2 card-side pop in transmit
    card_rd = 1; step();
    chk(head_data == 16'h3001 && tx_dma_req == 1, "R7 pop back under", head_data, 16'h3001);
    // random mix, compared each cycle
    for (int i = 0; i < 4000; i++) begin
      host_wr = 1'($urandom); card_wr = 1'($urandom);
      host_rd = 1'($urandom); card_rd = 1'($urandom);
      host_wdata = 16'($urandom); card_wdata = 16'($urandom);
      if (($urandom % 64) == 0) dir_rx = ~dir_rx;
      if (($urandom % 32) == 0) xfer_active = ~xfer_active;
      if (($urandom % 40) == 0) begin
        cfg_wr = 1; cfg_af_level = 5'($urandom); cfg_ae_level = 5'($urandom);
        cfg_rx_dma_en = 1'($urandom); cfg_tx_dma_en = 1'($urandom);
      end
      @(negedge clk);
      host_wr = 0; host_rd = 0; card_wr = 0; card_rd = 0; cfg_wr = 0;
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule